// File: doc/BRIEF.md
# Clock Generator Serial Configuration Slave

This block is the two-wire configuration port of a clock generator. It watches the SCL and SDA lines through synchronizers clocked by the system clock. It answers one write address and one read address, and it keeps a bank of 21 byte-wide control registers. Their contents are presented in parallel to the clock logic on a single flat bus.

Writes are block transfers. Any register written is reached through register 0, because the command byte and count byte that follow the address are acknowledged and then thrown away. Data bytes fill the bank from register 0 upward.

Reads return a length byte first and then the registers in ascending order. How many registers a read exposes is set by the content of register 8. Two register pairs are staged, so that a pair only takes effect when both of its bytes arrive together. The frequency-select strap pins are sampled during reset and stored inverted in register 5.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read) by pulling SDA low during the ninth clock. Any other address byte is not acknowledged, and the rest of that transfer leaves SDA released and the registers untouched.
- R2: Reset loads the following values:
  - register 5 is {0, inverted pin value in bits 6:4, 1111};
  - register 7 is 0x91;
  - register 8 is 0x08;
  - register 9 is 0x10;
  - register 15 is 0x9E;
  - registers 1–4 are 0xFF;
  - registers 16–20 are 0xAA;
  - registers 0, 6 and 10–14 are 0x00.
- R3: In a write, the command byte and the byte-count byte that follow the address are acknowledged and discarded. The data bytes then fill registers 0, 1, 2 and onward in order.
- R4: A register changes only after all eight bits of its byte have been received. A STOP or a repeated START in the middle of a byte leaves that register unchanged.
- R5: Data bytes beyond register 20 are acknowledged and discarded.
- R6: A data byte of 0x00 aimed at register 8 is ignored, and register 8 keeps its value.
- R7: Registers 11 and 12 update only when both are written in the same transfer. The same holds for registers 13 and 14. If only the lower one of a pair is written, neither register changes.
- R8: In a read, the first byte sent is the value of register 8, followed by register 0, 1, 2 and onward, each most significant bit first.
- R9: A read position above the value of register 8, or above 20, returns 0xFF.
- R10: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing further until the next START.
- R11: Register i appears on regBits bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rstN | input | 1 | Synchronous active-low reset; also samples the strap pins |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| fsPins | input | 3 | Frequency-select strap pins |
| sdaLow | output | 1 | When high, the pad pulls SDA low |
| regBits | output | 168 | All 21 registers, register i at bits [8i+7:8i] |

## Verification
The rising SCL edge that completes a byte's eighth bit commits that byte. A STOP or repeated START shares the same high phase of SCL. The bench ends transfers after four or five bits of a byte with a STOP, and also with a repeated START, and then confirms at the register bus that the partial byte was dropped while every complete byte before it was kept.

The second collision is between the pair staging and a transfer boundary. The bench ends a write right after the lower byte of a pair, and checks that neither byte of the pair moved.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int REG_COUNT = 21;
  localparam int IDX_W     = $clog2(REG_COUNT) + 1;
  localparam int IDX_MAX   = (1 << IDX_W) - 1;
  localparam int FS_REG    = 5;
  localparam int FS_LSB    = 4;
  localparam int FS_W      = 3;
  localparam int ID_REG    = 7;
  localparam int COUNT_REG = 8;
  localparam int WDOG_REG  = 9;
  localparam int SKEW_REG  = 15;
  localparam int SLEW_BASE = 16;
  localparam int PAIR_A    = 11;
  localparam int PAIR_B    = 13;
  localparam logic [7:0] WR_ADDR = 8'hD2;
  localparam logic [7:0] RD_ADDR = 8'hD3;

  // strobes from bus control to the register bank
  typedef struct packed {
    logic             wrEn;
    logic             clearPend;
    logic [IDX_W-1:0] idx;
    logic [7:0]       data;
  } bankCmd_t;

  function automatic bit isPairLo(input int i);
    return (i == PAIR_A) || (i == PAIR_B);
  endfunction

  function automatic bit isPairHi(input int i);
    return (i == PAIR_A + 1) || (i == PAIR_B + 1);
  endfunction

  function automatic logic [7:0] resetByte(input int i, input logic [FS_W-1:0] fs);
    logic [7:0] b;
    if (i == FS_REG) begin
      b = 8'h0F;
      b[FS_LSB +: FS_W] = ~fs;
    end
    else if (i == ID_REG)     b = 8'h91;
    else if (i == COUNT_REG)  b = 8'h08;
    else if (i == WDOG_REG)   b = 8'h10;
    else if (i == SKEW_REG)   b = 8'h9E;
    else if (i >= SLEW_BASE)  b = 8'hAA;
    else if (i >= 1 && i <= 4) b = 8'hFF;
    else                      b = 8'h00;
    return b;
  endfunction
endpackage

// File: rtl/cfg_bus_ctrl.sv
module cfg_bus_ctrl
  import cfg_slave_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  input  logic [7:0] cntByte,
  output bankCmd_t   cmd,
  output logic       sdaLow
);
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} busState_t;
  typedef enum logic [1:0] {ROLE_ADDR, ROLE_CMD, ROLE_CNT, ROLE_DATA} byteRole_t;

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow, sclRise, sclFall, startSeen, stopSeen;

  busState_t        state;
  byteRole_t        role;
  logic [2:0]       bitCnt;
  logic [6:0]       shiftReg;
  logic [7:0]       txShift;
  logic             byteFull, ackThis, readMode, masterAck;
  logic [IDX_W-1:0] idx, idxNext;
  logic [7:0]       rxByte;
  logic             lastBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  assign rxByte  = {shiftReg, sdaNow};
  assign lastBit = (bitCnt == 3'd7);
  assign idxNext = (idx == IDX_W'(IDX_MAX)) ? idx : idx + 1'b1;

  always_comb begin
    cmd.wrEn      = (state == S_RX) && sclRise && !byteFull && lastBit && (role == ROLE_DATA);
    cmd.clearPend = startSeen | stopSeen;
    cmd.idx       = idx;
    cmd.data      = rxByte;
  end

  always_comb begin
    case (state)
      S_RXACK: sdaLow = 1'b1;
      S_TX:    sdaLow = ~txShift[7];
      default: sdaLow = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      role      <= ROLE_ADDR;
      bitCnt    <= '0;
      shiftReg  <= '0;
      txShift   <= 8'hFF;
      byteFull  <= 1'b0;
      ackThis   <= 1'b0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
      idx       <= '0;
    end else if (startSeen) begin
      state    <= S_RX;
      role     <= ROLE_ADDR;
      bitCnt   <= '0;
      byteFull <= 1'b0;
      idx      <= '0;
    end else if (stopSeen) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_RX: begin
          if (sclRise && !byteFull) begin
            shiftReg <= rxByte[6:0];
            bitCnt   <= bitCnt + 3'd1;
            if (lastBit) begin
              byteFull <= 1'b1;
              if (role == ROLE_ADDR) begin
                ackThis  <= (rxByte == WR_ADDR) || (rxByte == RD_ADDR);
                readMode <= (rxByte == RD_ADDR);
              end else begin
                ackThis <= 1'b1;
              end
            end
          end else if (sclFall && byteFull) begin
            byteFull <= 1'b0;
            state    <= ackThis ? S_RXACK : S_IDLE;
          end
        end
        S_RXACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (role == ROLE_ADDR && readMode) begin
              state   <= S_TX;
              txShift <= cntByte;
            end else begin
              state <= S_RX;
              case (role)
                ROLE_ADDR: role <= ROLE_CMD;
                ROLE_CMD:  role <= ROLE_CNT;
                ROLE_CNT:  role <= ROLE_DATA;
                default:   idx  <= idxNext;
              endcase
            end
          end
        end
        S_TX: begin
          if (sclFall) begin
            if (lastBit) begin
              state  <= S_TXACK;
              bitCnt <= '0;
            end else begin
              txShift <= {txShift[6:0], 1'b1};
              bitCnt  <= bitCnt + 3'd1;
            end
          end
        end
        S_TXACK: begin
          if (sclRise) begin
            masterAck <= ~sdaNow;
          end else if (sclFall) begin
            if (masterAck) begin
              state   <= S_TX;
              txShift <= rdByte;
              idx     <= idxNext;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_slave_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [FS_W-1:0]        fsPins,
  input  bankCmd_t               cmd,
  output logic [7:0]             rdByte,
  output logic [7:0]             cntByte,
  output logic [REG_COUNT*8-1:0] regBits
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [7:0] bank [REG_COUNT];
  logic [7:0] pendByte;
  logic       pendValid;
  logic       pairCommit;

  assign pairCommit = cmd.wrEn && pendValid && isPairHi(int'(cmd.idx));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendByte  <= '0;
      pendValid <= 1'b0;
    end else if (cmd.clearPend || pairCommit) begin
      pendValid <= 1'b0;
    end else if (cmd.wrEn && isPairLo(int'(cmd.idx))) begin
      pendByte  <= cmd.data;
      pendValid <= 1'b1;
    end
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    logic       loadEn;
    logic [7:0] loadVal;
    logic [7:0] q;

    if (isPairLo(i)) begin : g_lo
      assign loadEn  = pairCommit && (cmd.idx == IDX_W'(i + 1));
      assign loadVal = pendByte;
    end else if (isPairHi(i)) begin : g_hi
      assign loadEn  = pairCommit && (cmd.idx == IDX_W'(i));
      assign loadVal = cmd.data;
    end else if (i == COUNT_REG) begin : g_cnt
      assign loadEn  = cmd.wrEn && (cmd.idx == IDX_W'(i)) && (cmd.data != 8'h00);
      assign loadVal = cmd.data;
    end else begin : g_plain
      assign loadEn  = cmd.wrEn && (cmd.idx == IDX_W'(i));
      assign loadVal = cmd.data;
    end

    always_ff @(posedge clk) begin
      if (!rstN)       q <= resetByte(i, fsPins);
      else if (loadEn) q <= loadVal;
    end

    assign bank[i]          = q;
    assign regBits[i*8 +: 8] = q;
  end

  assign cntByte = bank[COUNT_REG];

  always_comb begin
    rdByte = 8'hFF;
    for (int k = 0; k < REG_COUNT; k++) begin
      if (cmd.idx == IDX_W'(k) && k <= int'(bank[COUNT_REG])) rdByte = bank[k];
    end
  end
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
  import cfg_slave_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic [FS_W-1:0]        fsPins,
  output logic                   sdaLow,
  output logic [REG_COUNT*8-1:0] regBits
);
  timeunit 1ns;
  timeprecision 1ps;

  bankCmd_t   cmd;
  logic [7:0] rdByte, cntByte;

  cfg_bus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .cntByte(cntByte), .cmd(cmd), .sdaLow(sdaLow)
  );

  cfg_reg_bank u_bank (
    .clk(clk), .rstN(rstN), .fsPins(fsPins), .cmd(cmd),
    .rdByte(rdByte), .cntByte(cntByte), .regBits(regBits)
  );
endmodule

// File: rtl/cfg_slave_checker.sv
module cfg_slave_checker
  import cfg_slave_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclIn,
  input logic                   sdaLow,
  input logic [REG_COUNT*8-1:0] regBits
);
  timeunit 1ns;
  timeprecision 1ps;

  // R2: a reset cycle leaves the count register at its default
  p_reset_count_r2: assert property (@(posedge clk)
    !rstN |=> regBits[COUNT_REG*8 +: 8] == 8'h08);

  // R6: the count register never holds zero
  p_count_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    regBits[COUNT_REG*8 +: 8] != 8'h00);

  // R1: the slave changes its SDA drive only while SCL is low
  p_sda_scl_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLow != $past(sdaLow)) |-> !sclIn);

  // R4: registers commit only during the high phase that ends a byte
  p_commit_scl_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regBits != $past(regBits)) |-> sclIn);
endmodule

bind clkgen_cfg_slave cfg_slave_checker u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaLow(sdaLow), .regBits(regBits)
);

// File: tb/sim_clkgen_cfg_slave.sv
module sim_clkgen_cfg_slave;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NREG = 21;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] fsPins = 3'b010;
  logic sdaLow;
  logic sdaBus;
  logic [NREG*8-1:0] regBits;

  int nCmp = 0;
  int nBad = 0;
  logic [7:0] model [NREG];
  logic [7:0] buf8 [40];

  assign sdaBus = sdaM & ~sdaLow;
  always #2.5 clk = ~clk;

  clkgen_cfg_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .fsPins(fsPins), .sdaLow(sdaLow), .regBits(regBits)
  );

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic putBit(input bit b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(2); sclM = 1'b0; waitQ();
  endtask

  task automatic getBit(output bit b);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); b = sdaBus; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    bit x;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    getBit(x);
    acked = !x;
  endtask

  task automatic recvByte(output logic [7:0] b, input bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      getBit(x);
      b[i] = x;
    end
    putBit(!ack);
  endtask

  task automatic cmpRegs(input string tag);
    for (int i = 0; i < NREG; i++)
      check(regBits[i*8 +: 8] == model[i], $sformatf("%s reg%0d", tag, i),
            int'(regBits[i*8 +: 8]), int'(model[i]));
  endtask

  // block write of buf8[0..n-1]; model follows the requirements
  task automatic doWrite(input int n, input string tag);
    bit a;
    bit allAck = 1'b1;
    bit pend = 1'b0;
    logic [7:0] pv = 8'h00;
    busStart();
    sendByte(8'hD2, a); allAck &= a;
    sendByte(8'h5A, a); allAck &= a;
    sendByte(8'hC3, a); allAck &= a;
    for (int k = 0; k < n; k++) begin
      sendByte(buf8[k], a); allAck &= a;
      if (k < NREG) begin
        if (k == 11 || k == 13) begin
          pend = 1'b1; pv = buf8[k];
        end else if (k == 12 || k == 14) begin
          if (pend) begin model[k-1] = pv; model[k] = buf8[k]; end
          pend = 1'b0;
        end else if (!(k == 8 && buf8[k] == 8'h00)) begin
          model[k] = buf8[k];
        end
      end
    end
    busStop();
    check(allAck, {tag, " every byte acknowledged"}, int'(allAck), 1);
  endtask

  task automatic doRead(input int n);
    bit a;
    logic [7:0] b;
    logic [7:0] exp;
    busStart();
    sendByte(8'hD3, a);
    check(a, "R1 read address acknowledged", int'(a), 1);
    recvByte(b, 1'b1);
    check(b == model[8], "R8 length byte", int'(b), int'(model[8]));
    for (int p = 0; p < n; p++) begin
      recvByte(b, p != n - 1);
      exp = (p < NREG && p <= int'(model[8])) ? model[p] : 8'hFF;
      check(b == exp, $sformatf("R8/R9 read position %0d", p), int'(b), int'(exp));
    end
    check(sdaLow == 1'b0, "R10 SDA released after master NACK", int'(sdaLow), 0);
    waitQ(2);
    check(sdaLow == 1'b0, "R10 SDA stays released", int'(sdaLow), 0);
    busStop();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog R1..R11 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] keep;
    int lens [9] = '{1, 2, 4, 8, 12, 19, 20, 21, 27};

    for (int i = 0; i < NREG; i++) begin
      if (i == 5)                  model[i] = {1'b0, ~fsPins, 4'hF};
      else if (i == 7)             model[i] = 8'h91;
      else if (i == 8)             model[i] = 8'h08;
      else if (i == 9)             model[i] = 8'h10;
      else if (i == 15)            model[i] = 8'h9E;
      else if (i >= 16)            model[i] = 8'hAA;
      else if (i >= 1 && i <= 4)   model[i] = 8'hFF;
      else                         model[i] = 8'h00;
    end

    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    fsPins = 3'b111;
    cmpRegs("R2");
    check(regBits[5*8 +: 8] == 8'h5F, "R11 reg5 field at bits 47:40", int'(regBits[5*8 +: 8]), 'h5F);
    check(sdaLow == 1'b0, "R2 SDA released after reset", int'(sdaLow), 0);

    // foreign address
    busStart();
    sendByte(8'hA4, a);
    check(!a, "R1 foreign address not acknowledged", int'(a), 0);
    sendByte(8'h00, a);
    check(!a, "R1 ignored transfer stays silent", int'(a), 0);
    busStop();
    cmpRegs("R1 foreign");

    // short write: command and count discarded
    for (int k = 0; k < 7; k++) buf8[k] = 8'(8'h30 + k * 3);
    doWrite(7, "R3");
    cmpRegs("R3");

    // long write beyond the bank
    for (int k = 0; k < 26; k++) buf8[k] = 8'(k * 37 + 5);
    doWrite(26, "R5");
    cmpRegs("R5");

    // zero into count register
    for (int k = 0; k < 9; k++) buf8[k] = 8'(k + 8'h61);
    buf8[8] = 8'h00;
    keep = model[8];
    doWrite(9, "R6");
    check(regBits[8*8 +: 8] == keep, "R6 count register kept", int'(regBits[8*8 +: 8]), int'(keep));
    cmpRegs("R6");

    // pair staging
    for (int k = 0; k < 14; k++) buf8[k] = 8'(k * 11 + 8'h47);
    keep = model[11];
    doWrite(12, "R7");
    check(regBits[11*8 +: 8] == keep, "R7 lone lower pair byte dropped", int'(regBits[11*8 +: 8]), int'(keep));
    cmpRegs("R7 half");
    doWrite(14, "R7");
    cmpRegs("R7 full");

    // partial byte ended by STOP
    busStart();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h00, a);
    sendByte(8'hE1, a); model[0] = 8'hE1;
    sendByte(8'hE2, a); model[1] = 8'hE2;
    for (int i = 0; i < 4; i++) putBit(1'b0);
    busStop();
    cmpRegs("R4 stop");

    // partial byte ended by repeated START
    busStart();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h00, a);
    for (int i = 0; i < 5; i++) putBit(1'b1);
    busStart();
    sendByte(8'hD2, a);
    busStop();
    cmpRegs("R4 restart");

    // read-length sweep
    foreach (lens[j]) begin
      for (int k = 0; k < 8; k++) buf8[k] = model[k];
      buf8[8] = 8'(lens[j]);
      doWrite(9, "R8 set length");
      doRead(lens[j] + 3);
    end
    cmpRegs("R11 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule